// File: doc/BRIEF.md
# Frame Clock Ratio and Speed Mode Detector

This block watches a word-select (frame) signal that has already been synchronised to the system clock. It counts how many system-clock cycles each frame lasts, from one rising edge of word-select to the next, and matches that count against a fixed set of legal ratios. It also derives the frame rate from a system-clock frequency parameter and reports whether the stream runs at single speed or at double speed. Any period that fits no legal ratio, or that is illegal for the detected mode, is flagged as unsupported.

A lock state machine follows the stream of measurements. It raises a lock flag once the classification has stayed the same for several consecutive frames. It holds that classification through one bad frame, and it drops lock after a run of bad frames or when word-select stops toggling. Downstream logic uses the lock flag as permission to start conversion at the reported ratio and mode.

The state machine has four states. EMPTY means no reference classification is held; it is the state after reset and after a timeout. ACQ means a reference is held and matching frames are being counted. LOCK means locked. HOLD means locked, with at least one mismatched frame seen. The transitions are:
- EMPTY→ACQ on the first measurement.
- ACQ→ACQ, either counting up on a match or restarting on a mismatch.
- ACQ→LOCK on the fourth consecutive supported match.
- LOCK→HOLD on a mismatch.
- HOLD→LOCK on a match.
- HOLD→ACQ on the second consecutive mismatch.
- Any state→EMPTY on a timeout.

Top module: `clk_ratio_detect`

## Requirements
- R1: After reset, `locked`=0, `unsupported`=0, `dbl_mode`=0 and `ratio_code`=15.
- R2: A measured period P (system clocks between consecutive word-select rising edges) within ±2 of a legal ratio gives `ratio_code` equal to that ratio's index. The indexes are 32→0, 64→1, 128→2, 192→3, 256→4, 384→5, 512→6, 768→7 and 1024→8.
- R3: A period more than 2 away from every legal ratio sets `unsupported`=1 and `ratio_code`=15.
- R4: `dbl_mode`=1 exactly when P×67000 < SYS_CLK_HZ, which means the frame rate is above 67 kHz. This holds whether or not the period is supported.
- R5: A period is unsupported when its frame rate exceeds 200 kHz (P×200000 < SYS_CLK_HZ), or when double speed coincides with ratio index 0 or 1.
- R6: Before lock, each measurement is reported on the outputs. `locked` rises after four consecutive identical supported classifications, which takes five frame starts after reset.
- R7: While locked, a single mismatched frame keeps `locked`=1 and leaves the reported code and mode unchanged.
- R8: Two consecutive mismatched frames while locked clear `locked`, and the outputs then report the newest measurement.
- R9: If no word-select rising edge arrives within 2048 system clocks of the previous one, `locked` is cleared and the outputs return to their reset values.
- R10: An unsupported classification never produces lock, however often it repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ws | input | 1 | Word-select, already synchronised to clk |
| ratio_code | output | 4 | Index of matched ratio, 15 when none |
| dbl_mode | output | 1 | 1 = double speed, 0 = single speed |
| locked | output | 1 | Classification stable |
| unsupported | output | 1 | Period fits no legal ratio for the mode |

## Verification
The assertions assume that `ws` is already synchronous to `clk`, so each rising edge is seen as exactly one cycle of the high level following a low one. They also assume that the clock-frequency parameter matches the real system clock. The stimulus drives `ws` on the cycle grid, one clock after an edge, with whole frames of chosen length. It sweeps every legal ratio from three counts below to three counts above, so that each tolerance boundary falls on either side. Sequences of mixed frame lengths and a deliberately stalled `ws` exercise the lock, hold, drop and timeout paths.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

    localparam int         NUM_RATIOS = 9;
    localparam logic [3:0] CODE_NONE  = 4'hF;

    typedef struct packed {
        logic       unsup;
        logic       dbl;
        logic [3:0] code;
    } frame_class_t;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_ACQ,
        ST_LOCK,
        ST_HOLD
    } lock_state_t;

    // legal clocks-per-frame ratio for each code index
    function automatic int ratio_of(input int idx);
        int r;
        case (idx)
            0:       r = 32;
            1:       r = 64;
            2:       r = 128;
            3:       r = 192;
            4:       r = 256;
            5:       r = 384;
            6:       r = 512;
            7:       r = 768;
            8:       r = 1024;
            default: r = 0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/crd_period_meter.sv
module crd_period_meter #(
    parameter int TIMEOUT = 2048,
    parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ws,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] period_o,
    output logic             timeout_o
);

    logic             ws_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;

    assign rise         = ws & ~ws_q;
    assign meas_valid_o = rise & armed_q;
    assign period_o     = cnt_q + 1'b1;
    assign timeout_o    = armed_q && !rise && (cnt_q == CNT_W'(TIMEOUT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q    <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            ws_q <= ws;
            if (rise) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (timeout_o) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (armed_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= TIMEOUT - 1); // R9

    AST_TIMEOUT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/crd_ratio_classifier.sv
module crd_ratio_classifier
    import clk_ratio_pkg::*;
#(
    parameter int SYS_CLK_HZ  = 24_576_000,
    parameter int DBL_RATE_HZ = 67_000,
    parameter int MAX_RATE_HZ = 200_000,
    parameter int TOL         = 2,
    parameter int CNT_W       = 12
) (
    input  logic [CNT_W-1:0] period_i,
    output frame_class_t     cls_o
);

    // largest period whose rate is still above each limit
    localparam int DBL_MAX_CNT  = (SYS_CLK_HZ - 1) / DBL_RATE_HZ;
    localparam int FAST_MAX_CNT = (SYS_CLK_HZ - 1) / MAX_RATE_HZ;

    logic [NUM_RATIOS-1:0] hit;
    int                    p;

    assign p = int'(period_i);

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_match
        assign hit[i] = (p + TOL >= ratio_of(i)) && (p <= ratio_of(i) + TOL);
    end

    logic       found;
    logic [3:0] idx;
    logic       is_dbl;
    logic       too_fast;
    logic       bad;

    always_comb begin
        found = 1'b0;
        idx   = 4'd0;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (hit[i] && !found) begin
                found = 1'b1;
                idx   = 4'(i);
            end
        end
        is_dbl     = (p <= DBL_MAX_CNT);
        too_fast   = (p <= FAST_MAX_CNT);
        bad        = !found || too_fast || (is_dbl && (idx < 4'd2));
        cls_o.unsup = bad;
        cls_o.dbl   = is_dbl;
        cls_o.code  = bad ? CODE_NONE : idx;
    end

endmodule

// File: rtl/crd_lock_fsm.sv
module crd_lock_fsm
    import clk_ratio_pkg::*;
#(
    parameter int LOCK_FRAMES = 4,
    parameter int LOSE_FRAMES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         meas_valid_i,
    input  logic         timeout_i,
    input  frame_class_t meas_i,
    output logic         locked_o,
    output logic         unsup_o,
    output logic         dbl_o,
    output logic [3:0]   code_o
);

    localparam int RUN_W  = $clog2(LOCK_FRAMES + 1);
    localparam int MISS_W = $clog2(LOSE_FRAMES + 1);
    localparam frame_class_t CLS_RESET = '{unsup: 1'b0, dbl: 1'b0, code: CODE_NONE};

    lock_state_t  state_q, state_n;
    frame_class_t ref_q, ref_n;
    logic [RUN_W-1:0]  run_q, run_n;
    logic [MISS_W-1:0] miss_q, miss_n;
    logic same;

    assign same = (meas_i == ref_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            ref_q   <= CLS_RESET;
            run_q   <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_n;
            ref_q   <= ref_n;
            run_q   <= run_n;
            miss_q  <= miss_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        ref_n   = ref_q;
        run_n   = run_q;
        miss_n  = miss_q;
        if (timeout_i) begin
            state_n = ST_EMPTY;
            ref_n   = CLS_RESET;
            run_n   = '0;
            miss_n  = '0;
        end else if (meas_valid_i) begin
            unique case (state_q)
                ST_EMPTY: begin
                    state_n = ST_ACQ;
                    ref_n   = meas_i;
                    run_n   = RUN_W'(1);
                end
                ST_ACQ: begin
                    if (!same) begin
                        ref_n = meas_i;
                        run_n = RUN_W'(1);
                    end else if (!meas_i.unsup) begin
                        if (int'(run_q) + 1 >= LOCK_FRAMES) begin
                            state_n = ST_LOCK;
                            run_n   = '0;
                        end else begin
                            run_n = run_q + 1'b1;
                        end
                    end
                end
                ST_LOCK: begin
                    if (!same) begin
                        if (LOSE_FRAMES <= 1) begin
                            state_n = ST_ACQ;
                            ref_n   = meas_i;
                            run_n   = RUN_W'(1);
                        end else begin
                            state_n = ST_HOLD;
                            miss_n  = MISS_W'(1);
                        end
                    end
                end
                ST_HOLD: begin
                    if (same) begin
                        state_n = ST_LOCK;
                        miss_n  = '0;
                    end else if (int'(miss_q) + 1 >= LOSE_FRAMES) begin
                        state_n = ST_ACQ;
                        ref_n   = meas_i;
                        run_n   = RUN_W'(1);
                        miss_n  = '0;
                    end else begin
                        miss_n = miss_q + 1'b1;
                    end
                end
                default: state_n = ST_EMPTY;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_o <= 1'b0;
            unsup_o  <= 1'b0;
            dbl_o    <= 1'b0;
            code_o   <= CODE_NONE;
        end else begin
            locked_o <= (state_q == ST_LOCK) || (state_q == ST_HOLD);
            unsup_o  <= ref_q.unsup;
            dbl_o    <= ref_q.dbl;
            code_o   <= ref_q.code;
        end
    end

    AST_LOCK_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> !unsup_o); // R10

    AST_UNSUP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o |-> (code_o == CODE_NONE)); // R3

    AST_DBL_NO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_o && !unsup_o) |-> (code_o >= 4'd2)); // R5

    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && $past(locked_o)) |-> ($stable(code_o) && $stable(dbl_o))); // R7

    AST_TIMEOUT_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_i |=> ##1 !locked_o); // R9

endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
    import clk_ratio_pkg::*;
#(
    parameter int SYS_CLK_HZ  = 24_576_000,
    parameter int DBL_RATE_HZ = 67_000,
    parameter int MAX_RATE_HZ = 200_000,
    parameter int TOL         = 2,
    parameter int TIMEOUT     = 2048,
    parameter int LOCK_FRAMES = 4,
    parameter int LOSE_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ws,
    output logic [3:0] ratio_code,
    output logic       dbl_mode,
    output logic       locked,
    output logic       unsupported
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic             meas_valid;
    logic             timeout;
    logic [CNT_W-1:0] period;
    frame_class_t     cls;

    crd_period_meter #(
        .TIMEOUT (TIMEOUT),
        .CNT_W   (CNT_W)
    ) u_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .ws           (ws),
        .meas_valid_o (meas_valid),
        .period_o     (period),
        .timeout_o    (timeout)
    );

    crd_ratio_classifier #(
        .SYS_CLK_HZ  (SYS_CLK_HZ),
        .DBL_RATE_HZ (DBL_RATE_HZ),
        .MAX_RATE_HZ (MAX_RATE_HZ),
        .TOL         (TOL),
        .CNT_W       (CNT_W)
    ) u_class (
        .period_i (period),
        .cls_o    (cls)
    );

    crd_lock_fsm #(
        .LOCK_FRAMES (LOCK_FRAMES),
        .LOSE_FRAMES (LOSE_FRAMES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .meas_valid_i (meas_valid),
        .timeout_i    (timeout),
        .meas_i       (cls),
        .locked_o     (locked),
        .unsup_o      (unsupported),
        .dbl_o        (dbl_mode),
        .code_o       (ratio_code)
    );

endmodule

// File: tb/clk_ratio_detect_test.sv
`timescale 1ns/1ps
module clk_ratio_detect_test;

    localparam int SYS_HZ = 24_576_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ws = 1'b0;
    logic [3:0] ratio_code;
    logic       dbl_mode;
    logic       locked;
    logic       unsupported;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    clk_ratio_detect #(.SYS_CLK_HZ(SYS_HZ)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ws          (ws),
        .ratio_code  (ratio_code),
        .dbl_mode    (dbl_mode),
        .locked      (locked),
        .unsupported (unsupported)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic frame(input int p);
        ws = 1'b1;
        tick(p / 2);
        ws = 1'b0;
        tick(p - p / 2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ws    = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int legal_ratio(input int i);
        return (i < 2) ? (32 << i) : (((i % 2) == 0) ? (128 << ((i - 2) / 2)) : (192 << ((i - 3) / 2)));
    endfunction

    // expected {unsup, dbl, code} for a period, from R2..R5
    function automatic int expected_class(input int p);
        int  idx;
        bit  found;
        bit  dbl;
        bit  fast;
        bit  bad;
        found = 0;
        idx   = 0;
        for (int i = 0; i < 9; i++) begin
            int d;
            d = p - legal_ratio(i);
            if (!found && d >= -2 && d <= 2) begin
                found = 1;
                idx   = i;
            end
        end
        dbl  = (longint'(p) * 67000) < longint'(SYS_HZ);
        fast = (longint'(p) * 200000) < longint'(SYS_HZ);
        bad  = !found || fast || (dbl && idx < 2);
        return {26'd0, bad, dbl, (bad ? 4'hF : 4'(idx))};
    endfunction

    function automatic int observed();
        return {26'd0, unsupported, dbl_mode, ratio_code};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(2);
        do_reset();
        // R1: reset values
        check(locked == 1'b0 && unsupported == 1'b0 && dbl_mode == 1'b0 && ratio_code == 4'hF,
              "R1", observed(), 'hF);

        // R2 R3 R4 R5: sweep each legal ratio from -3 to +3 counts
        for (int i = 0; i < 9; i++) begin
            for (int off = -3; off <= 3; off++) begin
                int p;
                p = legal_ratio(i) + off;
                do_reset();
                frame(p);
                frame(p);
                check(observed() == expected_class(p),
                      (off == 3 || off == -3) ? "R3" : ((i < 2) ? "R5" : "R2_R4"),
                      observed(), expected_class(p));
            end
        end

        // R6: lock timing at 512 (single speed)
        do_reset();
        for (int k = 0; k < 4; k++) frame(512);
        check(locked == 1'b0, "R6 before", locked, 0);
        frame(512);
        check(locked == 1'b1, "R6 lock", locked, 1);
        check(ratio_code == 4'd6 && dbl_mode == 1'b0, "R6 code", ratio_code, 6);

        // R7: one odd frame keeps lock and values
        frame(300);
        frame(512);
        check(locked == 1'b1, "R7 lock", locked, 1);
        check(ratio_code == 4'd6 && dbl_mode == 1'b0 && unsupported == 1'b0, "R7 code", ratio_code, 6);
        frame(512);

        // R8: two mismatches drop lock, new value reported
        frame(256);
        frame(256);
        check(locked == 1'b1 && ratio_code == 4'd6, "R8 still", ratio_code, 6);
        frame(256);
        check(locked == 1'b0, "R8 drop", locked, 0);
        check(ratio_code == 4'd4 && dbl_mode == 1'b1, "R8 code", ratio_code, 4);

        // R6: lock at double speed 128
        do_reset();
        for (int k = 0; k < 5; k++) frame(128);
        check(locked == 1'b1 && ratio_code == 4'd2 && dbl_mode == 1'b1, "R6 dbl", ratio_code, 2);

        // R9: timeout
        do_reset();
        for (int k = 0; k < 6; k++) frame(512);
        tick(1400);
        check(locked == 1'b1, "R9 before", locked, 1);
        tick(200);
        check(locked == 1'b0, "R9 lock", locked, 0);
        check(ratio_code == 4'hF && dbl_mode == 1'b0 && unsupported == 1'b0, "R9 values", observed(), 'hF);

        // R10: repeated unsupported never locks
        do_reset();
        for (int k = 0; k < 8; k++) frame(300);
        check(locked == 1'b0, "R10 lock", locked, 0);
        check(unsupported == 1'b1, "R10 unsup", unsupported, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule